// File: doc/BRIEF.md
# Two-Wire Register Slave with Charge-Current Output

This block is the register-access end of a two-wire management bus. It oversamples the clock and data wires with the system clock. It answers only to the 7-bit device address 0001001 and pulls the data wire low through an open-drain enable. It holds a small file of 16-bit registers, and the register at pointer 0x14 is also driven onto a parallel output for the charge-current control logic next to it.

A host transaction always has the same shape. First comes a START and the address byte with its direction bit. Next comes a pointer byte that picks the register. Write data follows that, or a repeated START and a read. Each 16-bit register moves low byte first, and the pointer steps on after each high byte, so several registers can move in one burst.

Top module: `smb_regslave`

## Requirements
- R1: While no START has been seen since reset or since the last STOP, the block never pulls SDA low, whatever bytes are clocked on the bus.
- R2: Each byte takes nine SCL pulses and is sent MSB first, with the direction bit (0 = write, 1 = read) in the eighth place. When the first seven bits after a START equal 0001001, the block pulls SDA low for the whole ninth pulse.
- R3: On any other address the block leaves SDA released for the ninth pulse and for every later pulse until the next START, and the registers keep their values.
- R4: In a write transaction, the pointer byte and every data byte are acknowledged in their ninth pulse.
- R5: Write data fills the selected register low byte first, then high byte. The register at pointer 0x14 appears on `chg_cur_o` once its bytes are written.
- R6: In a read transaction the block shifts out the register chosen by the last pointer byte, low byte first, each byte MSB first. It changes SDA only after SCL falls.
- R7: The block releases SDA during the ninth pulse of each byte it sends. When the host answers with SDA high (NACK), the block sends nothing more until the next START.
- R8: After the high byte of a register has moved, in either direction, the pointer steps to the next register.
- R9: Registers exist at pointers 0x14 to 0x17. Bytes aimed at other pointers are still acknowledged. Writes to them are dropped and reads from them return 0x00.
- R10: A START in the middle of a transaction begins a new address match at once. The pointer and any bytes already written are kept.
- R11: After reset, SDA is released and `chg_cur_o` is zero.
- R12: The SDA drive changes only while SCL is low, apart from a release caused by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock wire as seen at the pin |
| sda_i | input | 1 | Bus data wire as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| chg_cur_o | output | 16 | Contents of the register at pointer 0x14 |

## Verification
Every bus edge takes two synchronizer flops and one edge register to reach the controller, so the SDA drive settles three clocks after the SCL fall that causes it. The bench holds each SCL level for eight clocks and reads SDA just before it drops SCL. A register write reaches `chg_cur_o` one clock after the controller sees the fall that ends the byte. The bench's reference model updates its expected value at that same fall, and the output is compared on every clock once SCL has been steady for five clocks. The same per-clock pass flags any change of the SDA drive inside a settled SCL-high phase.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int unsigned REG_W    = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam logic [6:0]  DEV_ADDR = 7'b0001001;
    localparam logic [7:0]  CHG_PTR  = 8'h14;
    localparam logic [3:0]  BIT_ACK  = 4'd8;
    localparam logic [3:0]  BIT_END  = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_IGN
    } smb_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic              we;
        logic [7:0]        ptr;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] half_of(input logic [REG_W-1:0] w, input logic hi);
        return hi ? w[REG_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync
    import smb_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '1;
        else     lvl_q <= lvl;
    end

    always_comb begin
        evt.scl      = lvl[1];
        evt.sda      = lvl[0];
        evt.scl_rise = lvl[1] & ~lvl_q[1];
        evt.scl_fall = ~lvl[1] & lvl_q[1];
        evt.start    = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
        evt.stop     = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
    end

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_pkg::*;
#(
    parameter int unsigned NREG = 4,
    parameter logic [7:0]  BASE = CHG_PTR
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [7:0]        rd_ptr,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [REG_W-1:0]  chg_cur_o
);
    localparam int unsigned IDX_W   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned CHG_IDX = int'(CHG_PTR) - int'(BASE);

    logic [REG_W-1:0] regs_q [NREG];
    logic [7:0]       wr_off;
    logic [7:0]       rd_off;
    logic             wr_hit;
    logic             rd_hit;

    assign wr_off = wr.ptr - BASE;
    assign rd_off = rd_ptr - BASE;
    assign wr_hit = wr.we && (wr_off < 8'(NREG));
    assign rd_hit = rd_off < 8'(NREG);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (wr_hit && (wr_off == 8'(i))) begin
                if (wr.hi) regs_q[i][REG_W-1:BYTE_W] <= wr.data;
                else       regs_q[i][BYTE_W-1:0]     <= wr.data;
            end
        end
    end

    assign rd_byte   = rd_hit ? half_of(regs_q[rd_off[IDX_W-1:0]], rd_hi) : '0;
    assign chg_cur_o = regs_q[CHG_IDX];

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_byte,
    output wr_req_t           wr,
    output logic [7:0]        rd_ptr,
    output logic              rd_hi,
    output logic              sda_oe,
    output smb_state_e        st_o,
    output logic [3:0]        bitcnt_o
);
    smb_state_e        st;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] sreg;
    logic [BYTE_W-1:0] txb;
    logic [7:0]        ptr;
    logic              bsel;
    logic              rw;
    logic              mack;
    logic              oe;
    logic              active;

    assign active = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_WDATA) || (st == ST_RDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sreg   <= '0;
            txb    <= '0;
            ptr    <= '0;
            bsel   <= 1'b0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            oe     <= 1'b0;
            wr     <= '0;
        end else begin
            wr.we <= 1'b0;
            if (evt.start) begin
                st     <= ST_ADDR;
                bitcnt <= '0;
                oe     <= 1'b0;
                bsel   <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                bitcnt <= '0;
                oe     <= 1'b0;
            end else if (active && evt.scl_rise) begin
                if (bitcnt < BIT_ACK) sreg <= {sreg[BYTE_W-2:0], evt.sda};
                else                  mack <= ~evt.sda;
                bitcnt <= bitcnt + 4'd1;
            end else if (active && evt.scl_fall) begin
                if (bitcnt == BIT_ACK) begin
                    unique case (st)
                        ST_ADDR: begin
                            if (sreg[7:1] == DEV_ADDR) begin
                                oe <= 1'b1;
                                rw <= sreg[0];
                            end else begin
                                st <= ST_IGN;
                                oe <= 1'b0;
                            end
                        end
                        ST_PTR: begin
                            ptr  <= sreg;
                            bsel <= 1'b0;
                            oe   <= 1'b1;
                        end
                        ST_WDATA: begin
                            wr   <= '{we: 1'b1, ptr: ptr, hi: bsel, data: sreg};
                            oe   <= 1'b1;
                            bsel <= ~bsel;
                            if (bsel) ptr <= ptr + 8'd1;
                        end
                        default: begin
                            oe   <= 1'b0;
                            bsel <= ~bsel;
                            if (bsel) ptr <= ptr + 8'd1;
                        end
                    endcase
                end else if (bitcnt == BIT_END) begin
                    bitcnt <= '0;
                    unique case (st)
                        ST_ADDR: begin
                            if (rw) begin
                                st  <= ST_RDATA;
                                oe  <= ~rd_byte[7];
                                txb <= {rd_byte[6:0], 1'b0};
                            end else begin
                                st <= ST_PTR;
                                oe <= 1'b0;
                            end
                        end
                        ST_PTR: begin
                            st <= ST_WDATA;
                            oe <= 1'b0;
                        end
                        ST_WDATA: oe <= 1'b0;
                        default: begin
                            if (mack) begin
                                oe  <= ~rd_byte[7];
                                txb <= {rd_byte[6:0], 1'b0};
                            end else begin
                                st <= ST_IGN;
                                oe <= 1'b0;
                            end
                        end
                    endcase
                end else if (st == ST_RDATA) begin
                    oe  <= ~txb[7];
                    txb <= {txb[6:0], 1'b0};
                end
            end
        end
    end

    assign rd_ptr   = ptr;
    assign rd_hi    = bsel;
    assign sda_oe   = oe;
    assign st_o     = st;
    assign bitcnt_o = bitcnt;

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
    import smb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned NREG        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic [REG_W-1:0] chg_cur_o
);
    bus_evt_t          evt;
    wr_req_t           wr;
    logic [7:0]        rd_ptr;
    logic              rd_hi;
    logic [BYTE_W-1:0] rd_byte;
    smb_state_e        ctl_st;
    logic [3:0]        ctl_bitcnt;

    smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    smb_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rd_byte  (rd_byte),
        .wr       (wr),
        .rd_ptr   (rd_ptr),
        .rd_hi    (rd_hi),
        .sda_oe   (sda_oe_o),
        .st_o     (ctl_st),
        .bitcnt_o (ctl_bitcnt)
    );

    smb_regfile #(.NREG(NREG), .BASE(CHG_PTR)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_ptr    (rd_ptr),
        .rd_hi     (rd_hi),
        .rd_byte   (rd_byte),
        .chg_cur_o (chg_cur_o)
    );

endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk
    import smb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_oe,
    input logic [REG_W-1:0] chg,
    input smb_state_e       st,
    input logic [3:0]       bitcnt,
    input bus_evt_t         evt
);
    assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_oe && chg == '0));

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    assert_frame_nine_R2: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= BIT_END);

    assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGN) |-> !sda_oe);

    assert_chg_from_write_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(chg) |-> ($past(st) == ST_WDATA));

    assert_host_slot_free_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDATA && bitcnt == BIT_END) |-> !sda_oe);

    assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(evt.scl) || $past(evt.start) || $past(evt.stop)));

endmodule

bind smb_regslave smb_regslave_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .sda_oe (sda_oe_o),
    .chg    (chg_cur_o),
    .st     (ctl_st),
    .bitcnt (ctl_bitcnt),
    .evt    (evt)
);

// File: tb/smb_regslave_tb.sv
`timescale 1ns/1ps
module smb_regslave_tb;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe_o;
    logic [15:0] chg_cur_o;
    logic        sda_bus;

    int n_tests = 0;
    int n_fail  = 0;
    bit checking = 1'b0;

    // behavioural reference model
    int          m_st = 0;   // 0 idle 1 addr 2 ptr 3 wdata 4 rdata 5 ignore
    logic [7:0]  m_ptr = 8'h00;
    bit          m_bsel = 1'b0;
    logic [15:0] m_regs [4] = '{16'h0, 16'h0, 16'h0, 16'h0};

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe_o;

    smb_regslave u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe_o  (sda_oe_o),
        .chg_cur_o (chg_cur_o)
    );

    function automatic bit in_win(input logic [7:0] p);
        return (p >= 8'h14) && (p <= 8'h17);
    endfunction

    task automatic m_rx(input logic [7:0] b, output bit ack);
        ack = 1'b0;
        case (m_st)
            1: begin
                if (b[7:1] == 7'b0001001) begin
                    ack = 1'b1;
                    m_st = b[0] ? 4 : 2;
                end else m_st = 5;
            end
            2: begin
                m_ptr = b; m_bsel = 1'b0; m_st = 3; ack = 1'b1;
            end
            3: begin
                ack = 1'b1;
                if (in_win(m_ptr)) begin
                    if (m_bsel) m_regs[int'(m_ptr) - 20][15:8] = b;
                    else        m_regs[int'(m_ptr) - 20][7:0]  = b;
                end
                if (m_bsel) m_ptr = m_ptr + 8'd1;
                m_bsel = ~m_bsel;
            end
            default: ack = 1'b0;
        endcase
    endtask

    task automatic m_tx(output logic [7:0] v);
        if (m_st == 4) begin
            v = in_win(m_ptr) ? (m_bsel ? m_regs[int'(m_ptr) - 20][15:8]
                                        : m_regs[int'(m_ptr) - 20][7:0]) : 8'h00;
            if (m_bsel) m_ptr = m_ptr + 8'd1;
            m_bsel = ~m_bsel;
        end else v = 8'hFF;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic hw();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b0; m_st = 1; m_bsel = 1'b0; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b1; m_st = 0; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        bit exp_ack;
        bit got_ack;
        exp_ack = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw();
            scl_m = 1'b1; hw();
            scl_m = 1'b0;
            if (i == 0) m_rx(b, exp_ack);
            hw();
        end
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        got_ack = ~sda_bus;
        scl_m = 1'b0; hw();
        check(req, {15'd0, got_ack}, {15'd0, exp_ack});
    endtask

    task automatic read_byte(input bit host_ack, input string req);
        logic [7:0] exp_v;
        logic [7:0] got_v;
        m_tx(exp_v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hw();
            scl_m = 1'b1; hw();
            got_v[i] = sda_bus;
            scl_m = 1'b0; hw();
        end
        check(req, {8'd0, got_v}, {8'd0, exp_v});
        sda_m = ~host_ack; hw();
        scl_m = 1'b1; hw();
        check("R7", {15'd0, sda_oe_o}, 16'd0);
        scl_m = 1'b0;
        if (m_st == 4 && !host_ack) m_st = 5;
        hw();
        sda_m = 1'b1;
    endtask

    // per-clock comparison against the model, once SCL has settled
    int   settle = 0;
    logic scl_last = 1'b1;
    logic oe_last = 1'b0;
    always @(posedge clk) begin
        #1;
        if (scl_m !== scl_last) settle = 0;
        else if (settle < 1000) settle++;
        scl_last = scl_m;
        if (checking && settle >= 5) check("R5", chg_cur_o, m_regs[0]);
        if (checking && scl_m && settle >= 4) check("R12", {15'd0, sda_oe_o}, {15'd0, oe_last});
        oe_last = sda_oe_o;
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R11", {15'd0, sda_oe_o}, 16'd0);
        check("R11", chg_cur_o, 16'h0000);
        checking = 1'b1;

        // write two registers from 0x14 (R2, R4, R5, R8)
        bus_start();
        send_byte(8'h12, "R2");
        send_byte(8'h14, "R4");
        send_byte(8'h34, "R4");
        send_byte(8'h12, "R4");
        check("R5", chg_cur_o, 16'h1234);
        send_byte(8'h78, "R8");
        send_byte(8'h56, "R8");
        bus_stop();

        // read back through a repeated start (R6, R7, R8, R10)
        bus_start();
        send_byte(8'h12, "R2");
        send_byte(8'h14, "R4");
        bus_start();
        send_byte(8'h13, "R10");
        read_byte(1'b1, "R6");
        read_byte(1'b1, "R6");
        read_byte(1'b1, "R8");
        read_byte(1'b0, "R8");
        read_byte(1'b1, "R7");
        bus_stop();

        // foreign address (R3)
        bus_start();
        send_byte(8'h14, "R3");
        send_byte(8'h14, "R3");
        send_byte(8'h00, "R3");
        bus_stop();
        check("R3", chg_cur_o, 16'h1234);

        // bytes without a START (R1)
        scl_m = 1'b0; hw();
        send_byte(8'h12, "R1");
        send_byte(8'h14, "R1");
        bus_stop();

        // pointer outside the file (R9)
        bus_start();
        send_byte(8'h12, "R9");
        send_byte(8'h20, "R9");
        send_byte(8'hAA, "R9");
        send_byte(8'hBB, "R9");
        bus_start();
        send_byte(8'h12, "R9");
        send_byte(8'h20, "R9");
        bus_start();
        send_byte(8'h13, "R9");
        read_byte(1'b1, "R9");
        read_byte(1'b0, "R9");
        bus_stop();
        check("R9", chg_cur_o, 16'h1234);

        // START cutting a write short (R10)
        bus_start();
        send_byte(8'h12, "R10");
        send_byte(8'h14, "R10");
        send_byte(8'h99, "R10");
        bus_start();
        send_byte(8'h12, "R10");
        send_byte(8'h16, "R10");
        send_byte(8'h11, "R10");
        send_byte(8'h22, "R10");
        bus_stop();
        check("R10", chg_cur_o, 16'h1299);
        bus_start();
        send_byte(8'h12, "R10");
        send_byte(8'h16, "R10");
        bus_start();
        send_byte(8'h13, "R10");
        read_byte(1'b1, "R6");
        read_byte(1'b0, "R6");
        bus_stop();

        // foreign address, then repeated START with the right one (R3, R10)
        bus_start();
        send_byte(8'h92, "R3");
        bus_start();
        send_byte(8'h12, "R10");
        send_byte(8'h15, "R10");
        bus_start();
        send_byte(8'h13, "R10");
        read_byte(1'b1, "R10");
        read_byte(1'b0, "R10");
        bus_stop();

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule